// File: doc/BRIEF.md
# Per-Byte Timing Profile Accumulator

This block gathers timing statistics for side-channel profiling work. Each sample is a wide input word of sixteen bytes together with a measured execution time. For every byte position, and for every value that byte can take, the block keeps a running sum of times and a hit count. It also keeps a global time sum and a global sample count. Every accepted sample therefore lands in sixteen bins at once, one per byte position.

Once collection is done, a result is fetched by giving a bin address made of the byte position and the byte value. The block forms the mean time of that bin and the mean time over all samples. It then returns their signed difference in fixed point with eight fractional bits. A single long division unit serves both means, and a bin that was never hit returns zero without a division.

A synchronous clear command sweeps the bin store to zero and resets the global totals before a new profiling run. Sample, clear and read commands are only taken while the block is idle, which it shows by raising its sample-ready output.

Top module: `tprof_acc`

## Requirements
- R1: After reset `smp_ready` is high. A sample is taken on a rising edge with `smp_valid` and `smp_ready` both high. `smp_ready` then stays low for exactly 16 cycles, one bin update per cycle, and rises again.
- R2: An accepted sample adds `smp_time` to the sum of bin {i, byte i} and increments that bin's count, for every position i from 0 to 15. Byte i is `smp_bytes[8*i+7:8*i]`. Equal byte values at different positions update separate bins.
- R3: Every accepted sample adds its time to a global sum and increments a global count. These form the overall mean used by all readouts.
- R4: For a bin with a nonzero count, the returned deviation is floor(256*sum/count) minus floor(256*gsum/gcount). It is a 25-bit two's complement value with 8 fractional bits, and it is negative when the bin is faster than the mean.
- R5: A bin with zero count returns a deviation of 0, and the divider is not started for it. `rd_valid` rises on the second rising edge after the read request is accepted.
- R6: `rd_addr[11:8]` selects the byte position and `rd_addr[7:0]` selects the byte value.
- R7: A clear command zeroes every bin and the global totals. `smp_ready` is low for exactly 4096 cycles while the bins are swept.
- R8: When commands arrive together while idle, clear wins over sample and sample wins over read. A command that loses is dropped, and no command is taken while `smp_ready` is low.
- R9: `rd_valid` is a one-cycle pulse for each accepted read. `rd_dev` keeps its value until the next result, and both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clear command, taken while idle |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Block idle; all commands are accepted only while high |
| smp_bytes | input | 128 | Sixteen input bytes, byte i at bits 8*i+7..8*i |
| smp_time | input | 16 | Measured execution time of the sample |
| rd_req | input | 1 | Deviation read request |
| rd_addr | input | 12 | Bin address {position[3:0], value[7:0]} |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_dev | output | 25 | Signed deviation, 8 fractional bits |

## Verification
On every cycle, the assertions check several handshake and ordering rules. An accepted sample or clear drops ready on the next cycle. The divider is never started with a zero divisor. A zero-count bin always yields a zero result on the following edge. The result strobe lasts a single cycle, and the result holds steady between strobes. The arithmetic itself can only be shown by the bench's scenarios. That covers the sixteen-way bin spread, the floor rounding of both means, the sign of the deviation, the address split, the busy lengths of update and clear, and the command priority. The bench checks each of these against a model that keeps its own sums and counts.

// File: rtl/tprof_pkg.sv
// Package: shared controller state encoding for the timing profile accumulator.
// Assumes: nothing beyond standard SystemVerilog.
package tprof_pkg;

    typedef enum logic [2:0] {
        S_IDLE,       // waiting for a command
        S_UPD,        // one bin read-modify-write per cycle
        S_CLR,        // sweeping the bin store to zero
        S_DIVB_GO,    // launch bin-mean division
        S_DIVB_WAIT,  // wait for bin-mean quotient
        S_DIVG_GO,    // launch global-mean division
        S_DIVG_WAIT,  // wait for global-mean quotient
        S_OUT         // form and publish the deviation
    } tprof_state_t;

endpackage

// File: rtl/tprof_mem.sv
// Module: bin store with a single address port, asynchronous read and
// synchronous write, so a read-modify-write completes in one cycle.
// Assumes: contents are undefined until the controller sweeps them clear.
module tprof_mem #(
    parameter int AW = 12,
    parameter int WW = 48
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [WW-1:0] wdata,
    output logic [WW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] ram [DEPTH];

    // Write port: store the word at the shared address.
    always_ff @(posedge clk) begin
        if (we) begin
            ram[addr] <= wdata;
        end
    end

    // Read port: current word at the shared address.
    assign rdata = ram[addr];

endmodule

// File: rtl/tprof_div.sv
// Module: unsigned restoring divider producing one quotient bit per cycle.
// Takes NW cycles after start, then pulses done with the low OUTW bits of
// the quotient on quotient.
// Assumes: divisor is nonzero at start; start is not raised while running.
module tprof_div #(
    parameter int NW   = 40,
    parameter int DW   = 16,
    parameter int OUTW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NW-1:0]   dividend,
    input  logic [DW-1:0]   divisor,
    output logic            done,
    output logic [OUTW-1:0] quotient
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0] quo;
    logic [DW-1:0] rem;
    logic [DW-1:0] dsr;
    logic [CW-1:0] cnt;
    logic          run;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem, quo[NW-1]};
        diff  = trial - {1'b0, dsr};
        fits  = (trial >= {1'b0, dsr});
    end

    // Iteration register: load on start, then shift one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo  <= '0;
            rem  <= '0;
            dsr  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            quo  <= dividend;
            rem  <= '0;
            dsr  <= divisor;
            cnt  <= '0;
            run  <= 1'b1;
            done <= 1'b0;
        end else if (run) begin
            quo  <= {quo[NW-2:0], fits};
            rem  <= fits ? diff[DW-1:0] : trial[DW-1:0];
            cnt  <= cnt + CW'(1);
            if (cnt == CW'(NW - 1)) begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient = quo[OUTW-1:0];

endmodule

// File: rtl/tprof_acc.sv
// Module: per-byte timing profile accumulator (top).
// Each sample updates NBYTES bins, one per cycle, addressed by
// {byte position, byte value}, and updates global totals. A read forms
// floor(sum*2^FRAC/count) minus floor(gsum*2^FRAC/gcount) with one shared
// divider. A zero-count bin reads as zero without using the divider.
// Assumes: a clear command is issued before the first profiling run, and
// counts and sums stay within CNTW and TIMEW+CNTW bits.
module tprof_acc
    import tprof_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int VALW   = 8,
    parameter int TIMEW  = 16,
    parameter int CNTW   = 16,
    parameter int FRAC   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             smp_valid,
    output logic                             smp_ready,
    input  logic [NBYTES*VALW-1:0]           smp_bytes,
    input  logic [TIMEW-1:0]                 smp_time,
    input  logic                             rd_req,
    input  logic [$clog2(NBYTES)+VALW-1:0]   rd_addr,
    output logic                             rd_valid,
    output logic [TIMEW+FRAC:0]              rd_dev
);
    localparam int POSW  = $clog2(NBYTES);
    localparam int AW    = POSW + VALW;
    localparam int DEPTH = 1 << AW;
    localparam int SUMW  = TIMEW + CNTW;
    localparam int WW    = SUMW + CNTW;
    localparam int NW    = SUMW + FRAC;
    localparam int QW    = TIMEW + FRAC;
    localparam int DEVW  = QW + 1;

    tprof_state_t          state;
    logic [POSW-1:0]       upd_idx;
    logic [AW-1:0]         clr_idx;
    logic [NBYTES*VALW-1:0] smp_lat;
    logic [TIMEW-1:0]      time_lat;
    logic [SUMW-1:0]       gsum;
    logic [CNTW-1:0]       gcnt;
    logic [SUMW-1:0]       ent_sum;
    logic [CNTW-1:0]       ent_cnt;
    logic [QW-1:0]         bin_avg;
    logic [QW-1:0]         g_avg;
    logic                  zero_rd;
    logic                  out_stage;

    logic                  mem_we;
    logic [AW-1:0]         mem_addr;
    logic [WW-1:0]         mem_wdata;
    logic [WW-1:0]         mem_rdata;
    logic [SUMW-1:0]       mem_rd_sum;
    logic [CNTW-1:0]       mem_rd_cnt;

    logic                  div_start;
    logic [NW-1:0]         div_dividend;
    logic [CNTW-1:0]       div_divisor;
    logic                  div_done;
    logic [QW-1:0]         div_q;

    logic                  clr_go;
    logic                  smp_go;
    logic                  rd_go;

    logic [VALW-1:0]       byte_arr [NBYTES];

    // Split the latched sample into per-position byte lanes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign byte_arr[g] = smp_lat[g*VALW +: VALW];
    end

    assign mem_rd_sum = mem_rdata[WW-1:CNTW];
    assign mem_rd_cnt = mem_rdata[CNTW-1:0];
    assign smp_ready  = (state == S_IDLE);
    assign out_stage  = (state == S_OUT);

    // Command arbitration while idle: clear, then sample, then read.
    always_comb begin
        clr_go = smp_ready && clr;
        smp_go = smp_ready && !clr && smp_valid;
        rd_go  = smp_ready && !clr && !smp_valid && rd_req;
    end

    // Bin store address and write data for update, sweep and read.
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = rd_addr;
        mem_wdata = '0;
        case (state)
            S_UPD: begin
                mem_we    = 1'b1;
                mem_addr  = {upd_idx, byte_arr[upd_idx]};
                mem_wdata = {mem_rd_sum + SUMW'(time_lat), mem_rd_cnt + CNTW'(1)};
            end
            S_CLR: begin
                mem_we   = 1'b1;
                mem_addr = clr_idx;
            end
            default: ;
        endcase
    end

    // Divider operand selection for the bin mean and the global mean.
    always_comb begin
        div_start    = (state == S_DIVB_GO) || (state == S_DIVG_GO);
        div_dividend = (state == S_DIVG_GO) ? {gsum, {FRAC{1'b0}}}
                                            : {ent_sum, {FRAC{1'b0}}};
        div_divisor  = (state == S_DIVG_GO) ? gcnt : ent_cnt;
    end

    // Controller: sequences updates, clears, divisions and result output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            upd_idx  <= '0;
            clr_idx  <= '0;
            smp_lat  <= '0;
            time_lat <= '0;
            gsum     <= '0;
            gcnt     <= '0;
            ent_sum  <= '0;
            ent_cnt  <= '0;
            bin_avg  <= '0;
            g_avg    <= '0;
            zero_rd  <= 1'b0;
            rd_valid <= 1'b0;
            rd_dev   <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (clr_go) begin
                        gsum    <= '0;
                        gcnt    <= '0;
                        clr_idx <= '0;
                        state   <= S_CLR;
                    end else if (smp_go) begin
                        smp_lat  <= smp_bytes;
                        time_lat <= smp_time;
                        gsum     <= gsum + SUMW'(smp_time);
                        gcnt     <= gcnt + CNTW'(1);
                        upd_idx  <= '0;
                        state    <= S_UPD;
                    end else if (rd_go) begin
                        ent_sum <= mem_rd_sum;
                        ent_cnt <= mem_rd_cnt;
                        zero_rd <= (mem_rd_cnt == '0);
                        if (mem_rd_cnt == '0) begin
                            bin_avg <= '0;
                            g_avg   <= '0;
                            state   <= S_OUT;
                        end else begin
                            state <= S_DIVB_GO;
                        end
                    end
                end
                S_UPD: begin
                    upd_idx <= upd_idx + POSW'(1);
                    if (upd_idx == POSW'(NBYTES - 1)) begin
                        state <= S_IDLE;
                    end
                end
                S_CLR: begin
                    clr_idx <= clr_idx + AW'(1);
                    if (clr_idx == AW'(DEPTH - 1)) begin
                        state <= S_IDLE;
                    end
                end
                S_DIVB_GO: state <= S_DIVB_WAIT;
                S_DIVB_WAIT: begin
                    if (div_done) begin
                        bin_avg <= div_q;
                        state   <= S_DIVG_GO;
                    end
                end
                S_DIVG_GO: state <= S_DIVG_WAIT;
                S_DIVG_WAIT: begin
                    if (div_done) begin
                        g_avg <= div_q;
                        state <= S_OUT;
                    end
                end
                S_OUT: begin
                    rd_valid <= 1'b1;
                    rd_dev   <= $signed({1'b0, bin_avg}) - $signed({1'b0, g_avg});
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    tprof_mem #(
        .AW (AW),
        .WW (WW)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    tprof_div #(
        .NW   (NW),
        .DW   (CNTW),
        .OUTW (QW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .done     (div_done),
        .quotient (div_q)
    );

endmodule

// File: rtl/tprof_acc_chk.sv
// Module: protocol checker for the timing profile accumulator, attached by bind.
// Assumes: synchronous active-low reset shared with the design.
module tprof_acc_chk #(
    parameter int DEVW = 25,
    parameter int DVW  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            smp_valid,
    input logic            smp_ready,
    input logic            rd_valid,
    input logic [DEVW-1:0] rd_dev,
    input logic            div_start,
    input logic [DVW-1:0]  div_divisor,
    input logic            zero_rd,
    input logic            out_stage
);

    AST_BUSY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);                 // R1

    AST_BUSY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && smp_ready) |=> !smp_ready);                       // R7

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> (div_divisor != '0));                       // R5

    AST_ZERO_BIN_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stage && zero_rd) |=> (rd_valid && rd_dev == '0));   // R5

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                  // R9

    AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_dev));                           // R9

endmodule

bind tprof_acc tprof_acc_chk #(
    .DEVW (DEVW),
    .DVW  (CNTW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .smp_valid   (smp_valid),
    .smp_ready   (smp_ready),
    .rd_valid    (rd_valid),
    .rd_dev      (rd_dev),
    .div_start   (div_start),
    .div_divisor (div_divisor),
    .zero_rd     (zero_rd),
    .out_stage   (out_stage)
);

// File: tb/tprof_acc_tb.sv
// Scoreboard bench: read tasks push model deviations into a queue, and a
// monitor pops and compares them whenever rd_valid strobes.
module tprof_acc_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         smp_valid = 1'b0;
    logic [127:0] smp_bytes = '0;
    logic [15:0]  smp_time = '0;
    logic         rd_req = 1'b0;
    logic [11:0]  rd_addr = '0;
    wire          smp_ready;
    wire          rd_valid;
    wire  [24:0]  rd_dev;

    longint m_sum [16][256];
    longint m_cnt [16][256];
    longint g_sum = 0;
    longint g_cnt = 0;
    longint exp_q [$];
    string  tag_q [$];
    int     checks = 0;
    int     failures = 0;
    logic [31:0] rs = 32'h1357_9bdf;

    always #2 clk = ~clk;

    tprof_acc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_bytes (smp_bytes),
        .smp_time  (smp_time),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_dev    (rd_dev)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic longint expect_dev(input int p, input int v);
        longint b;
        longint g;
        if (m_cnt[p][v] == 0) return 0;
        b = (m_sum[p][v] * 256) / m_cnt[p][v];
        g = (g_sum * 256) / g_cnt;
        return b - g;
    endfunction

    task automatic model_clear();
        for (int p = 0; p < 16; p++)
            for (int v = 0; v < 256; v++) begin
                m_sum[p][v] = 0;
                m_cnt[p][v] = 0;
            end
        g_sum = 0;
        g_cnt = 0;
    endtask

    task automatic model_sample(input logic [127:0] b, input logic [15:0] t);
        for (int i = 0; i < 16; i++) begin
            m_sum[i][b[i*8 +: 8]] += longint'(t);
            m_cnt[i][b[i*8 +: 8]] += 1;
        end
        g_sum += longint'(t);
        g_cnt += 1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
    endtask

    task automatic count_busy(output int busy);
        busy = 0;
        while (!smp_ready) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic do_clear(output int busy);
        wait_idle();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        count_busy(busy);
    endtask

    task automatic do_sample(input logic [127:0] b, input logic [15:0] t, output int busy);
        wait_idle();
        smp_valid = 1'b1;
        smp_bytes = b;
        smp_time  = t;
        @(negedge clk);
        smp_valid = 1'b0;
        model_sample(b, t);
        count_busy(busy);
    endtask

    task automatic do_read(input int p, input int v, input string tag);
        wait_idle();
        rd_addr = {p[3:0], v[7:0]};
        rd_req  = 1'b1;
        exp_q.push_back(expect_dev(p, v));
        tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each strobed result with the oldest expected item.
    always @(negedge clk) begin
        longint e;
        longint a;
        string  t;
        if (rst_n && rd_valid) begin
            a = longint'($signed(rd_dev));
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R9 unexpected rd_valid", a, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(a == e, t, a, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int busy;
        int n;
        logic [127:0] b;
        logic [127:0] last_b;
        logic [31:0] r;
        logic [24:0] held;
        model_clear();
        last_b = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(smp_ready == 1'b1, "R1 ready after reset", longint'(smp_ready), 1);
        chk(rd_valid == 1'b0, "R9 rd_valid after reset", longint'(rd_valid), 0);
        chk(rd_dev == '0, "R9 rd_dev after reset", longint'(rd_dev), 0);

        do_clear(busy);
        chk(busy == 4096, "R7 clear busy length", busy, 4096);

        // R5: zero-count bin latency, value and hold afterwards.
        wait_idle();
        rd_addr = 12'h3_21;
        rd_req  = 1'b1;
        exp_q.push_back(0);
        tag_q.push_back("R5 zero-count bin");
        @(negedge clk);
        rd_req = 1'b0;
        n = 1;
        while (!rd_valid) begin
            n++;
            @(negedge clk);
        end
        chk(n == 2, "R5 zero-count latency", n, 2);
        held = rd_dev;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R9 strobe one cycle", longint'(rd_valid), 0);
        chk(rd_dev == held, "R9 result held", longint'(rd_dev), longint'(held));

        do_sample('0, 16'd100, busy);
        chk(busy == 16, "R1 update busy length", busy, 16);
        do_read(0, 0, "R3 single sample gives zero");

        for (int i = 0; i < 16; i++) b[i*8 +: 8] = 8'(i);
        do_sample(b, 16'd300, busy);
        do_read(3, 3, "R4 positive deviation");
        do_read(3, 0, "R4 negative deviation");
        do_read(0, 0, "R2 bin shared by both samples");
        do_read(1, 0, "R6 position 1 value 0");
        do_read(0, 1, "R6 position 0 value 1");

        // Pseudo-random samples with fractional means.
        for (int s = 0; s < 20; s++) begin
            for (int i = 0; i < 16; i++) begin
                r = nxt();
                b[i*8 +: 8] = r[3:0] == 4'h0 ? 8'h00 : r[7:0];
            end
            r = nxt();
            do_sample(b, 16'(r[9:0] + 10'd37), busy);
            last_b = b;
        end
        for (int i = 0; i < 16; i += 3)
            do_read(i, int'(last_b[i*8 +: 8]), "R4 random bin");
        do_read(15, 0, "R4 often hit bin");

        // R2: one value at all positions lands in separate bins.
        do_sample({16{8'h55}}, 16'd901, busy);
        do_read(7, 8'h55, "R2 repeated value pos 7");
        do_read(12, 8'h55, "R2 repeated value pos 12");

        // R8: clear beats sample and read.
        wait_idle();
        clr = 1'b1;
        smp_valid = 1'b1;
        smp_bytes = {16{8'h77}};
        smp_time = 16'd500;
        rd_req = 1'b1;
        rd_addr = 12'h0_00;
        @(negedge clk);
        clr = 1'b0;
        smp_valid = 1'b0;
        rd_req = 1'b0;
        model_clear();
        count_busy(busy);
        chk(busy == 4096, "R8 clear wins", busy, 4096);
        do_read(0, 8'h77, "R8 sample dropped by clear");
        do_read(3, 3, "R7 bins zero after clear");

        // R8: sample beats read.
        wait_idle();
        smp_valid = 1'b1;
        smp_bytes = {16{8'h10}};
        smp_time = 16'd64;
        rd_req = 1'b1;
        rd_addr = 12'h2_10;
        @(negedge clk);
        smp_valid = 1'b0;
        rd_req = 1'b0;
        model_sample({16{8'h10}}, 16'd64);
        count_busy(busy);
        chk(busy == 16, "R8 sample wins over read", busy, 16);

        // R3: a byte fixed across all samples tracks the global mean.
        for (int s = 0; s < 5; s++) begin
            for (int i = 0; i < 15; i++) begin
                r = nxt();
                b[i*8 +: 8] = r[7:0];
            end
            b[127:120] = 8'hAA;
            r = nxt();
            do_sample(b, 16'(r[11:0] + 12'd5), busy);
        end
        do_read(15, 8'hAA, "R3 fixed byte bin");
        do_read(2, int'(b[23:16]), "R3 random bin vs global");
        do_read(15, 8'h10, "R3 early sample bin");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule